// File: doc/BRIEF.md
# Quick-Channel Trigger and Completion Controller

This block is the register-mapped control plane for a set of quick DMA channels. Software ties each channel to one parameter slot and to one 32-bit word inside that slot. The parameter-slot window is not stored here. Instead, the block watches register writes that fall into that window. When a write lands on the word a channel is tied to, and that channel is enabled, the block pulses a transfer event toward the sequencer.

Every channel keeps three state bits: enabled, secondary and missed. The secondary bit records that an event is outstanding. A trigger that arrives while the secondary bit is still set does not raise a second event; it sets the missed bit. When the data mover finishes, it returns a channel number and a completion code. The code sets one bit of a 64-bit pending register, and the channel's secondary bit is released at the same time. Software polls the pending bits and clears them by writing ones.

Reads are combinational and return the addressed register in the same cycle. Writes take effect at the next clock edge.

Top module: `qdma_trigger_ctrl`

## Requirements
- R1: After reset, all state is zero and `evt_vec` is zero. This covers every channel map, the enable, secondary and missed bits, and both pending halves.
- R2: The map register of channel ch sits at 0x200 + 4*ch. Its bits 13:5 hold the slot number and bits 4:2 hold the word index. A read returns those fields with every other bit zero.
- R3: The trigger address is 0x4000 + 32*slot + 4*word. A write there raises `evt_vec[ch]` for exactly one cycle, in the cycle after the write, and sets the channel's secondary bit. This happens for every mapped, enabled channel whose secondary bit is clear. A write to any other word raises no event. Several channels mapped to the same word fire together.
- R4: A trigger on a disabled channel raises no event and leaves its secondary and missed bits unchanged.
- R5: A trigger on an enabled channel whose secondary bit is set raises no event and sets that channel's missed bit.
- R6: Writing ones to 0x108C enables the channels whose bits are one. Writing ones to 0x1088 disables them. Both registers read as zero. The enable state reads at 0x1080, one bit per channel.
- R7: Writing ones to 0x1094 clears the matching secondary bits, and writing ones to 0x314 clears the matching missed bits. The secondary bits read at 0x1090 and the missed bits at 0x310.
- R8: A completion with code c sets pending bit c. Codes 0 to 31 appear at bit c of 0x1068, and codes 32 to 63 at bit c-32 of 0x106C. The same completion clears the secondary bit of the channel it names.
- R9: Writing ones to 0x1070 clears pending bits 0 to 31, and writing ones to 0x1074 clears bits 32 to 63. If a completion sets a bit in the same cycle that a write clears it, the bit ends set.
- R10: A map register written with zero in bits 13:2 unmaps the channel. A mapping of slot 0, word 0 therefore cannot be made. An unmapped channel never fires.
- R11: A trigger and a completion on the same channel in the same cycle count as a fresh trigger. The trigger raises an event, keeps the secondary bit set, and leaves the missed bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cmpl_valid | input | 1 | Completion returned by the data mover |
| cmpl_chan | input | 3 | Channel that completed |
| cmpl_code | input | 6 | Completion code selecting the pending bit |
| evt_vec | output | 8 | One-cycle transfer event, one bit per channel |

## Verification
The bound checker watches four rules on every cycle. An event is only raised for a channel that was enabled, and it always comes with that channel's secondary bit set. A missed bit only rises on a channel whose secondary bit was already set. A completion always leaves its pending bit set, and a write-one clear of the low half leaves no written bit set unless a completion collided with it. Some behaviours can only be shown by the bench scenarios, because they depend on which addresses were written. These are the address decode of the map and trigger words, the read-as-zero set and clear registers, the two pending halves, unmapping by a zero write, and the same-cycle trigger/completion and clear/completion orderings.

// File: rtl/qdma_pkg.sv
// Package: address map and shared types of the quick-channel controller.
// Assumes a 16-bit byte address space and 32-bit register words.
package qdma_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SLOT_W = 9;
    localparam int WORD_W = 3;

    localparam logic [ADDR_W-1:0] OFS_MAP_BASE  = 16'h0200;
    localparam logic [ADDR_W-1:0] OFS_MISS_STAT = 16'h0310;
    localparam logic [ADDR_W-1:0] OFS_MISS_CLR  = 16'h0314;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO   = 16'h1068;
    localparam logic [ADDR_W-1:0] OFS_PEND_HI   = 16'h106C;
    localparam logic [ADDR_W-1:0] OFS_PCLR_LO   = 16'h1070;
    localparam logic [ADDR_W-1:0] OFS_PCLR_HI   = 16'h1074;
    localparam logic [ADDR_W-1:0] OFS_EN_STAT   = 16'h1080;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR    = 16'h1088;
    localparam logic [ADDR_W-1:0] OFS_EN_SET    = 16'h108C;
    localparam logic [ADDR_W-1:0] OFS_SEC_STAT  = 16'h1090;
    localparam logic [ADDR_W-1:0] OFS_SEC_CLR   = 16'h1094;

    // Slot window: top two address bits 01 select 0x4000..0x7FFF.
    localparam logic [1:0] SLOT_WIN_TAG = 2'b01;

    // One channel's mapping: the watched slot and word, plus a valid flag.
    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] word;
    } chmap_t;
endpackage

// File: rtl/qdma_reg_decode.sv
// Module: turns a register write into per-function strobes and trigger info.
// Assumes word-aligned accesses; misaligned writes decode to nothing.
module qdma_reg_decode
    import qdma_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [NCH-1:0]    map_wr,
    output logic              en_set,
    output logic              en_clr,
    output logic              sec_clr,
    output logic              miss_clr,
    output logic              pclr_lo,
    output logic              pclr_hi,
    output logic              trig_wr,
    output logic [SLOT_W-1:0] trig_slot,
    output logic [WORD_W-1:0] trig_word
);
    // Per-channel map write strobes at MAP_BASE + 4*ch.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_map
        assign map_wr[ch] = reg_wr && (reg_addr == OFS_MAP_BASE + ADDR_W'(4 * ch));
    end

    // Control register write strobes.
    assign en_set   = reg_wr && (reg_addr == OFS_EN_SET);
    assign en_clr   = reg_wr && (reg_addr == OFS_EN_CLR);
    assign sec_clr  = reg_wr && (reg_addr == OFS_SEC_CLR);
    assign miss_clr = reg_wr && (reg_addr == OFS_MISS_CLR);
    assign pclr_lo  = reg_wr && (reg_addr == OFS_PCLR_LO);
    assign pclr_hi  = reg_wr && (reg_addr == OFS_PCLR_HI);

    // Snoop of writes into the parameter-slot window.
    assign trig_wr   = reg_wr && (reg_addr[ADDR_W-1 -: 2] == SLOT_WIN_TAG)
                       && (reg_addr[1:0] == 2'b00);
    assign trig_slot = reg_addr[WORD_W+2 +: SLOT_W];
    assign trig_word = reg_addr[2 +: WORD_W];
endmodule

// File: rtl/qdma_chan_slice.sv
// Module: state of one quick channel (map, enable, secondary, missed, event).
// Assumes the decoder's strobes are one-hot per write; a completion is
// applied before a trigger in the same cycle.
module qdma_chan_slice
    import qdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int IDX = 0,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_wr,
    input  logic [13:2]       map_wdata,
    input  logic              wbit,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              sec_clr,
    input  logic              miss_clr,
    input  logic              trig_wr,
    input  logic [SLOT_W-1:0] trig_slot,
    input  logic [WORD_W-1:0] trig_word,
    input  logic              cmpl_valid,
    input  logic [CH_W-1:0]   cmpl_chan,
    output logic [DATA_W-1:0] map_rd,
    output logic              en_q,
    output logic              sec_q,
    output logic              miss_q,
    output logic              evt_q
);
    chmap_t map_q;
    logic   hit, done, sec_eff, fire, miss_set;

    // Trigger and completion qualification.
    always_comb begin
        hit      = trig_wr && map_q.vld && (map_q.slot == trig_slot)
                   && (map_q.word == trig_word);
        done     = cmpl_valid && (cmpl_chan == CH_W'(IDX));
        sec_eff  = sec_q && !done;
        fire     = hit && en_q && !sec_eff;
        miss_set = hit && en_q && sec_eff;
    end

    // Channel map register; an all-zero field write unmaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (map_wr) begin
            map_q.slot <= map_wdata[13:5];
            map_q.word <= map_wdata[4:2];
            map_q.vld  <= |map_wdata;
        end
    end

    // Enable, secondary, missed bits and the registered event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sec_q  <= 1'b0;
            miss_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            if (en_set && wbit)      en_q <= 1'b1;
            else if (en_clr && wbit) en_q <= 1'b0;
            sec_q  <= fire || (sec_eff && !(sec_clr && wbit));
            miss_q <= miss_set || (miss_q && !(miss_clr && wbit));
            evt_q  <= fire;
        end
    end

    assign map_rd = DATA_W'({map_q.slot, map_q.word, 2'b00});
endmodule

// File: rtl/qdma_pend_bank.sv
// Module: completion pending bits, set by code and cleared by write-one.
// Assumes 2^CODE_W pending bits split into two halves of DATA_W bits.
module qdma_pend_bank
    import qdma_pkg::*;
#(
    parameter int CODE_W = 6,
    localparam int NPEND = 1 << CODE_W,
    localparam int HALF  = NPEND / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [CODE_W-1:0] set_code,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic [HALF-1:0]   clr_mask,
    output logic [NPEND-1:0]  pend_q
);
    logic [NPEND-1:0] set_vec, clr_vec;

    // Decode the completion code and the clear masks.
    always_comb begin
        set_vec = set_vld ? (NPEND'(1) << set_code) : '0;
        clr_vec = {clr_hi ? clr_mask : '0, clr_lo ? clr_mask : '0};
    end

    // Pending register: a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= set_vec | (pend_q & ~clr_vec);
    end
endmodule

// File: rtl/qdma_trigger_ctrl.sv
// Module: top of the quick-channel trigger and completion controller.
// Assumes NCH <= 32 and 2^CODE_W == 2 * 32 so each status fits one word.
module qdma_trigger_ctrl
    import qdma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CODE_W = 6,
    localparam int CH_W  = $clog2(NCH),
    localparam int NPEND = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [15:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cmpl_valid,
    input  logic [CH_W-1:0]   cmpl_chan,
    input  logic [CODE_W-1:0] cmpl_code,
    output logic [NCH-1:0]    evt_vec
);
    logic [NCH-1:0]    map_wr, en_vec, sec_vec, miss_vec;
    logic [DATA_W-1:0] map_rd [NCH];
    logic              en_set, en_clr, sec_clr, miss_clr, pclr_lo, pclr_hi, trig_wr;
    logic [SLOT_W-1:0] trig_slot;
    logic [WORD_W-1:0] trig_word;
    logic [NPEND-1:0]  pend_vec;

    qdma_reg_decode #(.NCH(NCH)) u_dec (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .map_wr(map_wr),
        .en_set(en_set), .en_clr(en_clr), .sec_clr(sec_clr), .miss_clr(miss_clr),
        .pclr_lo(pclr_lo), .pclr_hi(pclr_hi), .trig_wr(trig_wr),
        .trig_slot(trig_slot), .trig_word(trig_word)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        qdma_chan_slice #(.NCH(NCH), .IDX(ch)) u_slice (
            .clk(clk), .rst_n(rst_n), .map_wr(map_wr[ch]),
            .map_wdata(reg_wdata[13:2]), .wbit(reg_wdata[ch]),
            .en_set(en_set), .en_clr(en_clr), .sec_clr(sec_clr), .miss_clr(miss_clr),
            .trig_wr(trig_wr), .trig_slot(trig_slot), .trig_word(trig_word),
            .cmpl_valid(cmpl_valid), .cmpl_chan(cmpl_chan),
            .map_rd(map_rd[ch]), .en_q(en_vec[ch]), .sec_q(sec_vec[ch]),
            .miss_q(miss_vec[ch]), .evt_q(evt_vec[ch])
        );
    end

    qdma_pend_bank #(.CODE_W(CODE_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vld(cmpl_valid), .set_code(cmpl_code),
        .clr_lo(pclr_lo), .clr_hi(pclr_hi), .clr_mask(reg_wdata[NPEND/2-1:0]),
        .pend_q(pend_vec)
    );

    // Read multiplexer; set/clear registers and unknown addresses read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_PEND_LO:   reg_rdata = pend_vec[NPEND/2-1:0];
            OFS_PEND_HI:   reg_rdata = pend_vec[NPEND-1:NPEND/2];
            OFS_EN_STAT:   reg_rdata = DATA_W'(en_vec);
            OFS_SEC_STAT:  reg_rdata = DATA_W'(sec_vec);
            OFS_MISS_STAT: reg_rdata = DATA_W'(miss_vec);
            default: begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (reg_addr == OFS_MAP_BASE + ADDR_W'(4 * ch)) reg_rdata = map_rd[ch];
                end
            end
        endcase
    end
endmodule

// File: rtl/qdma_trigger_ctrl_chk.sv
// Module: assertion checker bound to the controller top.
// Assumes the default 64 pending bits and a synchronous active-low reset.
module qdma_trigger_ctrl_chk #(
    parameter int NCH    = 8,
    parameter int CODE_W = 6,
    localparam int CH_W  = $clog2(NCH),
    localparam int NPEND = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [15:0]       reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              cmpl_valid,
    input logic [CH_W-1:0]   cmpl_chan,
    input logic [CODE_W-1:0] cmpl_code,
    input logic [NCH-1:0]    evt_vec,
    input logic [NCH-1:0]    en_vec,
    input logic [NCH-1:0]    sec_vec,
    input logic [NCH-1:0]    miss_vec,
    input logic [NPEND-1:0]  pend_vec
);
    AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec & ~$past(en_vec)) == '0); // R4
    AST_EVT_HOLDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec & ~sec_vec) == '0); // R3
    AST_MISS_AFTER_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_vec & ~$past(miss_vec)) & ~$past(sec_vec)) == '0); // R5
    AST_CMPL_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> pend_vec[$past(cmpl_code)]); // R8
    AST_PCLR_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 16'h1070 && !cmpl_valid)
        |=> ((pend_vec[31:0] & $past(reg_wdata)) == 32'h0)); // R9
endmodule

bind qdma_trigger_ctrl qdma_trigger_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmpl_valid(cmpl_valid), .cmpl_chan(cmpl_chan),
    .cmpl_code(cmpl_code), .evt_vec(evt_vec), .en_vec(en_vec), .sec_vec(sec_vec),
    .miss_vec(miss_vec), .pend_vec(pend_vec)
);

// File: tb/tb_qdma_trigger_ctrl.sv
// Bench: scoreboard of expected event vectors plus register read checks.
module tb_qdma_trigger_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmpl_valid = 1'b0;
    logic [2:0]  cmpl_chan = '0;
    logic [5:0]  cmpl_code = '0;
    logic [7:0]  evt_vec;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] exp_q [$];

    qdma_trigger_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmpl_valid(cmpl_valid),
        .cmpl_chan(cmpl_chan), .cmpl_code(cmpl_code), .evt_vec(evt_vec)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] trig_addr(int slot, int word);
        return 16'(32'h4000 + 32 * slot + 4 * word);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Data mover stub: returns a completion after a delay.
    task automatic mover(logic [2:0] ch, logic [5:0] code, int dly);
        repeat (dly) @(negedge clk);
        @(negedge clk);
        cmpl_valid = 1'b1; cmpl_chan = ch; cmpl_code = code;
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    // Monitor: every event must match the next scoreboard entry.
    always @(negedge clk) begin
        if (rst_n && evt_vec != '0) begin
            if (exp_q.size() == 0) check("R3 unexpected event", 32'(evt_vec), 32'h0);
            else check("R3 event", 32'(evt_vec), 32'(exp_q.pop_front()));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1", 16'h1068, 0); rd_chk("R1", 16'h106C, 0);
        rd_chk("R1", 16'h1080, 0); rd_chk("R1", 16'h0204, 0);
        check("R1 evt", 32'(evt_vec), 0);
        // R2 map write with junk bits
        wr(16'h0208, 32'hFFFF_C003 | (5 << 5) | (3 << 2));
        rd_chk("R2", 16'h0208, 32'h0000_00AC);
        // R4 disabled channel ignores its trigger
        wr(trig_addr(5, 3), 32'h1);
        rd_chk("R4 sec", 16'h1090, 0); rd_chk("R4 miss", 16'h0310, 0);
        // R6 enable set; set/clear read zero
        wr(16'h108C, 32'h04);
        rd_chk("R6 stat", 16'h1080, 32'h04);
        rd_chk("R6 set reads 0", 16'h108C, 0); rd_chk("R6 clr reads 0", 16'h1088, 0);
        // R3 other word does not fire; mapped word fires
        wr(trig_addr(5, 2), 32'h1);
        rd_chk("R3 no fire", 16'h1090, 0);
        exp_q.push_back(8'h04);
        wr(trig_addr(5, 3), 32'h1);
        rd_chk("R3 sec", 16'h1090, 32'h04);
        // R5 second trigger while outstanding
        wr(trig_addr(5, 3), 32'h1);
        rd_chk("R5 miss", 16'h0310, 32'h04);
        // R7 missed clear
        wr(16'h0314, 32'h04);
        rd_chk("R7 miss clr", 16'h0310, 0);
        // R8 completions into both halves
        mover(3'd2, 6'd40, 4);
        rd_chk("R8 hi", 16'h106C, 32'h100); rd_chk("R8 sec freed", 16'h1090, 0);
        mover(3'd2, 6'd3, 2);
        rd_chk("R8 lo", 16'h1068, 32'h8);
        // R9 write-one clear, and set beats clear in the same cycle
        wr(16'h1074, 32'h100);
        rd_chk("R9 hi clr", 16'h106C, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 16'h1070; reg_wdata = 32'h8;
        cmpl_valid = 1'b1; cmpl_chan = 3'd0; cmpl_code = 6'd3;
        @(negedge clk);
        reg_wr = 1'b0; cmpl_valid = 1'b0;
        rd_chk("R9 set wins", 16'h1068, 32'h8);
        wr(16'h1070, 32'h8);
        rd_chk("R9 lo clr", 16'h1068, 0);
        // R7 secondary clear after a fresh event
        exp_q.push_back(8'h04);
        wr(trig_addr(5, 3), 32'h1);
        wr(16'h1094, 32'h04);
        rd_chk("R7 sec clr", 16'h1090, 0);
        // R11 trigger and completion together on an outstanding channel
        exp_q.push_back(8'h04);
        wr(trig_addr(5, 3), 32'h1);
        exp_q.push_back(8'h04);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = trig_addr(5, 3); reg_wdata = 32'h1;
        cmpl_valid = 1'b1; cmpl_chan = 3'd2; cmpl_code = 6'd1;
        @(negedge clk);
        reg_wr = 1'b0; cmpl_valid = 1'b0;
        rd_chk("R11 miss", 16'h0310, 0); rd_chk("R11 sec", 16'h1090, 32'h04);
        // R6 disable then trigger ignored
        wr(16'h1094, 32'h04);
        wr(16'h1088, 32'h04);
        rd_chk("R6 disabled", 16'h1080, 0);
        wr(trig_addr(5, 3), 32'h1);
        rd_chk("R6 ignored", 16'h1090, 0);
        // R10 map, fire, unmap, no fire
        wr(16'h021C, (7 << 5) | (1 << 2));
        wr(16'h108C, 32'h80);
        exp_q.push_back(8'h80);
        wr(trig_addr(7, 1), 32'h1);
        wr(16'h1094, 32'h80);
        wr(16'h021C, 32'h0);
        rd_chk("R10 map", 16'h021C, 0);
        wr(trig_addr(7, 1), 32'h1); wr(trig_addr(0, 0), 32'h1);
        rd_chk("R10 no fire", 16'h1090, 0);
        // R3 two channels on one word fire together
        wr(16'h0204, (9 << 5) | (7 << 2)); wr(16'h020C, (9 << 5) | (7 << 2));
        wr(16'h108C, 32'h0A);
        exp_q.push_back(8'h0A);
        wr(trig_addr(9, 7), 32'h1);
        rd_chk("R3 pair sec", 16'h1090, 32'h0A);
        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule